// File: doc/BRIEF.md
# Adaptive Slave-Port Arbiter

This block sits in front of one slave port of a multi-layer interconnect and decides which of several master input ports may drive that slave. Each master presents a request, a priority level, a preferred tenure length, its slave-select line toward this slave, a bus-lock flag and an end-of-transaction pulse. The shared lock flag comes from the master that currently holds the port.

At every decision the arbiter compares the priority levels of the candidates. If they are all equal, a rotating pointer picks the winner. Otherwise the highest level wins. The winner's preferred length is loaded into a tenure counter, so the grant lasts that many transfers. A length of 1 re-arbitrates on every transfer. A large length keeps the grant for the whole burst, unless the master ends early. Both outputs come straight from flip-flops: the granted master index and an idle flag. The idle flag tells the output stage to drive idle address and control to the slave.

Top module: `sm_slave_arb`

## Requirements
- R1: When every candidate has the same priority level, the winner is the first candidate found scanning upward (with wrap) from the rotating pointer.
- R2: When candidates' priority levels differ, the candidate with the numerically largest level wins, with ties among that level going to the lowest index.
- R3: While a master holds the port and `bus_lock` is 1 at an enabled edge, the grant and `port_idle` do not change.
- R4: With no master holding the port and no request, `port_idle` stays 1 and `grant_id` keeps its value.
- R5: A grant loads the tenure counter from the winner's length field (field i at bits [4i+3:4i] of `req_len`), with a value of 0 treated as 1. A grant of length L lasts L enabled edges when the master keeps its select high and does not finish early.
- R6: Before the tenure runs out, and while the holder's select is 1 and it does not signal transaction end, the holder keeps the port.
- R7: At tenure end with no other requester, the holder keeps the port (tenure reloaded) if its select is 1, otherwise `port_idle` becomes 1.
- R8: At tenure end with other requesters, the port goes to a winner among the other requesters, chosen by R1 or R2.
- R9: If the holder signals transaction end or drops its select before tenure ends, the port goes to a winner among the other requesters, or `port_idle` becomes 1 if there are none.
- R10: The rotating pointer moves to the winner's index plus one (mod 4) only on a grant decided by R1. It is unchanged otherwise.
- R11: On edges where `hready` is 0, no output or internal state changes.
- R12: After synchronous reset, `port_idle` is 1, `grant_id` is 0 and the rotating pointer is at master 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hready | input | 1 | Transfer-complete strobe. Decisions happen only when it is 1 |
| req | input | 4 | Per-master request |
| req_prio | input | 8 | Per-master priority level, 2 bits each, larger wins |
| req_len | input | 16 | Per-master tenure length, 4 bits each |
| hsel | input | 4 | Per-master select toward this slave |
| bus_lock | input | 1 | Lock flag of the current holder |
| txn_end | input | 4 | Per-master end-of-transaction pulse |
| grant_id | output | 2 | Registered index of the holding master |
| port_idle | output | 1 | Registered flag: no master holds the port |

## Verification
Assertions check the cycle-level rules on every clock: a stalled edge changes nothing, a locked holder keeps the port, an idle port with no requests stays idle, a new grant always goes to a master that was requesting, and a running tenure counts down by one. Which master wins, and the rotation order built up across many grants, can only be shown by the bench's scenarios. The bench compares every cycle against its own arithmetic model. It sweeps every request pattern against every priority assignment from reset, then runs a long biased random run that covers tenure expiry, early ends, locking and stalls.

// File: rtl/sm_arb_pkg.sv
package sm_arb_pkg;
    localparam int unsigned DEF_MASTERS  = 4;
    localparam int unsigned DEF_PRIO_W   = 2;
    localparam int unsigned DEF_LEN_W    = 4;

    typedef enum logic [2:0] {
        ACT_STALL,
        ACT_KEEP,
        ACT_TICK,
        ACT_GRANT,
        ACT_RELOAD,
        ACT_PARK
    } act_e;
endpackage

// File: rtl/sm_arb_rr.sv
module sm_arb_rr #(
    parameter int unsigned NM = 4,
    localparam int unsigned IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic [NM-1:0] cand,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < NM; k++) begin
            int j;
            j = (int'(ptr) + k) % NM;
            if (!found && cand[j]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/sm_arb_prio.sv
module sm_arb_prio #(
    parameter int unsigned NM = 4,
    parameter int unsigned PW = 2,
    localparam int unsigned IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic [NM-1:0]    cand,
    input  logic [NM*PW-1:0] prio,
    output logic             found,
    output logic [IW-1:0]    idx,
    output logic             all_equal
);
    logic [PW-1:0] best;
    logic [PW-1:0] first;

    always_comb begin
        found     = 1'b0;
        idx       = '0;
        best      = '0;
        first     = '0;
        all_equal = 1'b1;
        for (int i = 0; i < NM; i++) begin
            if (cand[i]) begin
                if (!found) begin
                    found = 1'b1;
                    idx   = IW'(i);
                    best  = prio[i*PW +: PW];
                    first = prio[i*PW +: PW];
                end else begin
                    if (prio[i*PW +: PW] != first) all_equal = 1'b0;
                    if (prio[i*PW +: PW] > best) begin
                        best = prio[i*PW +: PW];
                        idx  = IW'(i);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sm_arb_pick.sv
module sm_arb_pick #(
    parameter int unsigned NM = 4,
    parameter int unsigned PW = 2,
    localparam int unsigned IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic [NM-1:0]    cand,
    input  logic [NM*PW-1:0] prio,
    input  logic [IW-1:0]    rr_ptr,
    output logic             found,
    output logic [IW-1:0]    win,
    output logic             used_rr
);
    logic          rr_found, p_found, eq;
    logic [IW-1:0] rr_idx, p_idx;

    sm_arb_rr #(.NM(NM)) u_rr (
        .cand (cand),
        .ptr  (rr_ptr),
        .found(rr_found),
        .idx  (rr_idx)
    );

    sm_arb_prio #(.NM(NM), .PW(PW)) u_prio (
        .cand     (cand),
        .prio     (prio),
        .found    (p_found),
        .idx      (p_idx),
        .all_equal(eq)
    );

    assign found   = eq ? rr_found : p_found;
    assign win     = eq ? rr_idx : p_idx;
    assign used_rr = eq && rr_found;
endmodule

// File: rtl/sm_slave_arb.sv
module sm_slave_arb
    import sm_arb_pkg::*;
#(
    parameter int unsigned NM = DEF_MASTERS,
    parameter int unsigned PW = DEF_PRIO_W,
    parameter int unsigned LW = DEF_LEN_W,
    localparam int unsigned IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hready,
    input  logic [NM-1:0]    req,
    input  logic [NM*PW-1:0] req_prio,
    input  logic [NM*LW-1:0] req_len,
    input  logic [NM-1:0]    hsel,
    input  logic             bus_lock,
    input  logic [NM-1:0]    txn_end,
    output logic [IW-1:0]    grant_id,
    output logic             port_idle
);
    logic [IW-1:0] sel_q, sel_d, rr_q, rr_d;
    logic          idle_q, idle_d;
    logic [LW-1:0] cnt_q, cnt_d;
    logic [NM-1:0] cur_oh, cand;
    logic          found, used_rr;
    logic [IW-1:0] win;
    logic [LW-1:0] win_len, cur_len;
    logic          expired;
    act_e          act;

    function automatic logic [LW-1:0] eff_len(input logic [LW-1:0] v);
        return (v == '0) ? LW'(1) : v;
    endfunction

    assign cur_oh  = NM'(1) << sel_q;
    assign cand    = idle_q ? req : (req & ~cur_oh);
    assign win_len = eff_len(req_len[win*LW +: LW]);
    assign cur_len = eff_len(req_len[sel_q*LW +: LW]);
    assign expired = (cnt_q <= LW'(1));

    sm_arb_pick #(.NM(NM), .PW(PW)) u_pick (
        .cand   (cand),
        .prio   (req_prio),
        .rr_ptr (rr_q),
        .found  (found),
        .win    (win),
        .used_rr(used_rr)
    );

    always_comb begin
        if (!hready)                 act = ACT_STALL;
        else if (!idle_q && bus_lock) act = ACT_KEEP;
        else if (idle_q)             act = found ? ACT_GRANT : ACT_KEEP;
        else if (expired) begin
            if (found)               act = ACT_GRANT;
            else if (hsel[sel_q])    act = ACT_RELOAD;
            else                     act = ACT_PARK;
        end else if (txn_end[sel_q] || !hsel[sel_q])
                                     act = found ? ACT_GRANT : ACT_PARK;
        else                         act = ACT_TICK;
    end

    always_comb begin
        sel_d  = sel_q;
        idle_d = idle_q;
        cnt_d  = cnt_q;
        rr_d   = rr_q;
        unique case (act)
            ACT_GRANT: begin
                sel_d  = win;
                idle_d = 1'b0;
                cnt_d  = win_len;
                if (used_rr) rr_d = IW'((int'(win) + 1) % NM);
            end
            ACT_RELOAD: cnt_d  = cur_len;
            ACT_TICK:   cnt_d  = cnt_q - LW'(1);
            ACT_PARK:   idle_d = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            idle_q <= 1'b1;
            cnt_q  <= '0;
            rr_q   <= '0;
        end else begin
            sel_q  <= sel_d;
            idle_q <= idle_d;
            cnt_q  <= cnt_d;
            rr_q   <= rr_d;
        end
    end

    assign grant_id  = sel_q;
    assign port_idle = idle_q;

    logic [NM-1:0] req_seen;
    always_ff @(posedge clk) begin
        if (rst) req_seen <= '0;
        else     req_seen <= req;
    end

    // R11: a stalled edge leaves every register alone
    a_r11_stall_freeze: assert property (@(posedge clk) disable iff (rst)
        !hready |=> ($stable(grant_id) && $stable(port_idle) && $stable(cnt_q) && $stable(rr_q)));

    // R3: lock keeps the holder
    a_r3_lock_keeps: assert property (@(posedge clk) disable iff (rst)
        (hready && !port_idle && bus_lock) |=> (!port_idle && $stable(grant_id)));

    // R4: idle port with nobody asking stays idle
    a_r4_idle_stays: assert property (@(posedge clk) disable iff (rst)
        (hready && port_idle && (req == '0)) |=> (port_idle && $stable(grant_id)));

    // R1 / R2: a grant from idle lands on a master that was requesting
    a_r2_grant_requester: assert property (@(posedge clk) disable iff (rst)
        (hready && port_idle && (req != '0)) |=> (!port_idle && req_seen[grant_id]));

    // R6: running tenure counts down with the holder unchanged
    a_r6_tenure_tick: assert property (@(posedge clk) disable iff (rst)
        (hready && !port_idle && !bus_lock && (cnt_q > LW'(1)) && hsel[grant_id] && !txn_end[grant_id])
        |=> (!port_idle && $stable(grant_id) && (cnt_q == $past(cnt_q) - LW'(1))));

    // R5: a granted tenure is never zero
    a_r5_tenure_nonzero: assert property (@(posedge clk) disable iff (rst)
        !port_idle |-> (cnt_q != '0));
endmodule

// File: tb/sm_slave_arb_test.sv
`timescale 1ns/1ps
module sm_slave_arb_test;
    localparam int NM = 4;
    localparam int PW = 2;
    localparam int LW = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             hready = 1'b0;
    logic [NM-1:0]    req = '0;
    logic [NM*PW-1:0] req_prio = '0;
    logic [NM*LW-1:0] req_len = '0;
    logic [NM-1:0]    hsel = '0;
    logic             bus_lock = 1'b0;
    logic [NM-1:0]    txn_end = '0;
    logic [1:0]       grant_id;
    logic             port_idle;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sm_slave_arb uut (
        .clk(clk), .rst(rst), .hready(hready), .req(req), .req_prio(req_prio),
        .req_len(req_len), .hsel(hsel), .bus_lock(bus_lock), .txn_end(txn_end),
        .grant_id(grant_id), .port_idle(port_idle)
    );

    // bench model state
    int m_sel, m_rr, m_cnt;
    bit m_idle;

    function automatic int plevel(int i);
        return (req_prio >> (i*PW)) & 3;
    endfunction

    function automatic int tlen(int i);
        int v;
        v = (req_len >> (i*LW)) & 15;
        return (v == 0) ? 1 : v;
    endfunction

    // returns winner or -1; sets rr_used
    function automatic int choose(input logic [NM-1:0] c, output bit rr_used);
        int hi, lo, w;
        hi = -1; lo = 99; w = -1; rr_used = 0;
        for (int i = 0; i < NM; i++) if (c[i]) begin
            if (plevel(i) > hi) hi = plevel(i);
            if (plevel(i) < lo) lo = plevel(i);
        end
        if (hi < 0) return -1;
        if (hi == lo) begin
            rr_used = 1;
            for (int k = 0; k < NM; k++) begin
                int j;
                j = (m_rr + k) % NM;
                if (w < 0 && c[j]) w = j;
            end
        end else begin
            for (int i = NM-1; i >= 0; i--) if (c[i] && plevel(i) == hi) w = i;
        end
        return w;
    endfunction

    task automatic check(input string tag, input int got_sel, input int exp_sel,
                         input int got_idle, input int exp_idle);
        checks++;
        if (got_sel != exp_sel || got_idle != exp_idle) begin
            bad++;
            $display("FAIL %s: grant_id=%0d port_idle=%0d expected grant_id=%0d port_idle=%0d",
                     tag, got_sel, got_idle, exp_sel, exp_idle);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        #1;
        m_sel = 0; m_rr = 0; m_cnt = 0; m_idle = 1;
        check("R12 reset", grant_id, 0, port_idle, 1);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // advance one edge with inputs already driven; model then compare
    task automatic step();
        string tag;
        logic [NM-1:0] c;
        bit rru;
        int w;
        c = m_idle ? req : (req & ~(4'b1 << m_sel));
        w = choose(c, rru);
        if (!hready) tag = "R11 stall";
        else if (!m_idle && bus_lock) tag = "R3 lock";
        else if (m_idle) begin
            if (w < 0) tag = "R4 idle";
            else begin
                tag = rru ? "R1,R10 rr grant" : "R2 prio grant";
                m_sel = w; m_idle = 0; m_cnt = tlen(w);
                if (rru) m_rr = (w + 1) % NM;
            end
        end else if (m_cnt <= 1) begin
            if (w >= 0) begin
                tag = rru ? "R8,R1 expiry regrant" : "R8,R2 expiry regrant";
                m_sel = w; m_cnt = tlen(w);
                if (rru) m_rr = (w + 1) % NM;
            end else if (hsel[m_sel]) begin
                tag = "R7 expiry keep"; m_cnt = tlen(m_sel);
            end else begin
                tag = "R7 expiry park"; m_idle = 1;
            end
        end else if (txn_end[m_sel] || !hsel[m_sel]) begin
            if (w >= 0) begin
                tag = "R9 early regrant";
                m_sel = w; m_cnt = tlen(w);
                if (rru) m_rr = (w + 1) % NM;
            end else begin
                tag = "R9 early park"; m_idle = 1;
            end
        end else begin
            tag = "R5,R6 tenure"; m_cnt = m_cnt - 1;
        end
        @(posedge clk);
        #1;
        check(tag, grant_id, m_sel, port_idle, m_idle);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            bad++; checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // exhaustive: every request pattern x every priority assignment, first grant from reset
        for (int pc = 0; pc < 256; pc++) begin
            for (int rq = 1; rq < 16; rq++) begin
                do_reset();
                req_prio = pc[7:0]; req = rq[3:0]; req_len = 16'h1111;
                hsel = '1; bus_lock = 0; txn_end = '0; hready = 1;
                step();
            end
        end
        // directed tenure: master 2 alone with length 3, kept while selected
        do_reset();
        req_prio = '0; req_len = 16'h0300; req = 4'b0100; hsel = 4'b0100; hready = 1;
        step();                 // grant to 2
        req = 4'b0001;          // competitor waits out the tenure (R5)
        step(); step(); step(); // two ticks, then expiry regrant to 0
        check("R5 tenure end", grant_id, 0, port_idle, 0);
        // biased random run
        do_reset();
        for (int n = 0; n < 6000; n++) begin
            hready   = ($urandom % 100) < 85;
            req      = 4'($urandom);
            hsel     = (($urandom % 100) < 80) ? 4'hF : 4'($urandom);
            bus_lock = ($urandom % 100) < 10;
            txn_end  = (($urandom % 100) < 15) ? 4'($urandom) : 4'h0;
            req_len  = 16'($urandom) & 16'h3333;
            if (($urandom % 100) < 40) begin
                int p;
                p = $urandom % 4;
                req_prio = {4{p[1:0]}};
            end else req_prio = 8'($urandom);
            step();
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule